// File: doc/BRIEF.md
# Cursor Generator Host Register Port

This block is the host-facing side of a hardware cursor generator. A 16-bit host bus reaches the block through four ports, chosen by a 2-bit port select. Two of the ports load a 16-bit internal pointer one byte at a time. The other two are data windows: one reaches a file of thirteen byte-wide control registers, and the other reaches a 512-word by 16-bit cursor bitmap RAM. The shared pointer selects the location that either window touches, and every data access advances it. Software can therefore stream a run of registers or a whole cursor bitmap after setting the pointer once.

The control registers are exported as plain outputs, assembled into fields for the overlay logic: a command byte, 12-bit cursor X and Y, and 16-bit crosshair window X, Y, width and height. The overlay logic reads the bitmap RAM through a dedicated read-only port. Host transfers are single-cycle requests qualified by a valid strobe. Read data returns one cycle after the request, flagged by a read-valid strobe.

Top module: `cursor_host_port`

## Requirements
- R1: A request is taken on a clock edge where `bus_valid` is high; `bus_write` high means write. For a read, `bus_rvalid` is high and `bus_rdata` holds the result in the cycle after the request. `bus_rvalid` is low after any other cycle. Port select codes: 0 pointer low byte, 1 pointer high byte, 2 cursor RAM data, 3 register data.
- R2: A write to port 0 loads pointer bits 7:0 from `bus_wdata[7:0]`. A write to port 1 loads pointer bits 15:8 from `bus_wdata[7:0]`. The other pointer byte is unchanged. A read of port 0 or 1 returns that pointer byte in bits 7:0 with bits 15:8 zero, and leaves the pointer unchanged.
- R3: Each read or write on port 3 touches the register whose index equals the pointer, and then adds one to the 16-bit pointer.
- R4: A register write takes its byte from `bus_wdata[7:0]`; the host replicates the byte in bits 15:8. A register read returns the byte in bits 7:0 with bits 15:8 zero.
- R5: Register indices: 0 command (`cmd_o`); 1/2 cursor X low/high; 3/4 cursor Y low/high; 5/6 window X low/high; 7/8 window Y low/high; 9/10 window width low/high; 11/12 window height low/high. Each pair drives its output as {high, low}.
- R6: Registers 2 and 4 keep only bits 3:0 of a write and read back bits 7:4 as zero. `cur_x_o` and `cur_y_o` are 12 bits wide.
- R7: A port 3 access with the pointer above 12 reads zero and changes no register, but still adds one to the pointer.
- R8: Port 2 reads or writes the full 16-bit RAM word at index pointer[8:0].
- R9: After a port 2 access the pointer becomes (pointer[8:0] + 1) mod 512, with bits 15:9 cleared, so 0x1FF wraps to 0x000.
- R10: `ovl_rdata` holds the RAM word at `ovl_addr` one cycle after the address is presented.
- R11: Reset (synchronous, active high) clears the pointer and all thirteen registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Host request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_port | input | 2 | Port select (0 ptr low, 1 ptr high, 2 RAM, 3 register) |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| ovl_addr | input | 9 | Overlay RAM read index |
| ovl_rdata | output | 16 | Overlay RAM read data |
| cmd_o | output | 8 | Command register |
| cur_x_o | output | 12 | Cursor X coordinate |
| cur_y_o | output | 12 | Cursor Y coordinate |
| win_x_o | output | 16 | Crosshair window X |
| win_y_o | output | 16 | Crosshair window Y |
| win_w_o | output | 16 | Crosshair window width |
| win_h_o | output | 16 | Crosshair window height |

## Verification
Host read data and `bus_rvalid` are due one cycle after the request edge. The bench drives each request just after a falling edge and samples at the next falling edge, which lies half a period after the capturing rising edge. Pointer changes and register writes show up on the register outputs and in a following address-port read, also one edge after the request. The overlay RAM port has the same one-cycle latency and is sampled the same way. Back-to-back accesses, the wrap at 0x1FF and out-of-range indices are each checked at the first cycle in which their effect is visible.

// File: rtl/cursor_port_pkg.sv
package cursor_port_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int PTR_W    = 16;
  localparam int RAM_AW   = 9;
  localparam int NUM_REGS = 13;

  typedef enum logic [1:0] {
    PORT_PTR_LO = 2'd0,
    PORT_PTR_HI = 2'd1,
    PORT_RAM    = 2'd2,
    PORT_REG    = 2'd3
  } port_e;

  // register indices used by the field assembly and the nibble mask
  localparam int IDX_CMD      = 0;
  localparam int IDX_CX_LO    = 1;
  localparam int IDX_CX_HI    = 2;
  localparam int IDX_CY_LO    = 3;
  localparam int IDX_CY_HI    = 4;
  localparam int IDX_WX_LO    = 5;
  localparam int IDX_WY_LO    = 7;
  localparam int IDX_WW_LO    = 9;
  localparam int IDX_WH_LO    = 11;
  localparam int COORD_HI_W   = 4;
endpackage

// File: rtl/cursor_ptr_unit.sv
module cursor_ptr_unit
  import cursor_port_pkg::*;
#(
  parameter int PW = PTR_W,
  parameter int AW = RAM_AW,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          wr_i,
  input  port_e         port_i,
  input  logic [BW-1:0] byte_i,
  output logic [PW-1:0] ptr_o
);
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;
  logic [AW-1:0] ram_next;

  assign ram_next = ptr_q[AW-1:0] + AW'(1);

  always_comb begin
    ptr_d = ptr_q;
    if (req_i) begin
      unique case (port_i)
        PORT_PTR_LO: if (wr_i) ptr_d[BW-1:0] = byte_i;
        PORT_PTR_HI: if (wr_i) ptr_d[PW-1:BW] = byte_i;
        PORT_REG:    ptr_d = ptr_q + PW'(1);
        PORT_RAM:    ptr_d = {{(PW-AW){1'b0}}, ram_next};
        default:     ptr_d = ptr_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/cursor_regfile.sv
module cursor_regfile
  import cursor_port_pkg::*;
#(
  parameter int NR = NUM_REGS,
  parameter int PW = PTR_W,
  parameter int BW = BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [PW-1:0]    ptr_i,
  input  logic [BW-1:0]    wdata_i,
  output logic [BW-1:0]    rdata_o,
  output logic [NR*BW-1:0] regs_o
);
  localparam logic [BW-1:0] NIB_MASK = BW'((1 << COORD_HI_W) - 1);

  for (genvar i = 0; i < NR; i++) begin : g_reg
    localparam logic [BW-1:0] KEEP =
      (i == IDX_CX_HI || i == IDX_CY_HI) ? NIB_MASK : {BW{1'b1}};
    logic [BW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (we_i && ptr_i == PW'(i)) q <= wdata_i & KEEP;
    end
    assign regs_o[i*BW +: BW] = q;
  end

  logic [BW-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NR; i++)
      if (ptr_i == PW'(i)) rd_sel = regs_o[i*BW +: BW];
  end

  logic [BW-1:0] rd_q;
  always_ff @(posedge clk) begin
    if (rst)       rd_q <= '0;
    else if (re_i) rd_q <= rd_sel;
  end
  assign rdata_o = rd_q;
endmodule

// File: rtl/cursor_bitmap_ram.sv
module cursor_bitmap_ram
  import cursor_port_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int AW = RAM_AW
) (
  input  logic          clk,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic [AW-1:0] b_addr_i,
  output logic [DW-1:0] b_rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en_i) begin
      if (a_we_i) mem[a_addr_i] <= a_wdata_i;
      a_rdata_o <= mem[a_addr_i];
    end
  end

  always_ff @(posedge clk) begin
    b_rdata_o <= mem[b_addr_i];
  end
endmodule

// File: rtl/cursor_host_port.sv
module cursor_host_port
  import cursor_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_port,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [RAM_AW-1:0] ovl_addr,
  output logic [WORD_W-1:0] ovl_rdata,
  output logic [7:0]        cmd_o,
  output logic [11:0]       cur_x_o,
  output logic [11:0]       cur_y_o,
  output logic [15:0]       win_x_o,
  output logic [15:0]       win_y_o,
  output logic [15:0]       win_w_o,
  output logic [15:0]       win_h_o
);
  port_e                    port_s;
  logic [PTR_W-1:0]         ptr_q;
  logic [BYTE_W-1:0]        reg_rdata;
  logic [WORD_W-1:0]        ram_rdata;
  logic [NUM_REGS*BYTE_W-1:0] regs_flat;
  logic                     reg_acc, ram_acc, rd_req;

  assign port_s  = port_e'(bus_port);
  assign reg_acc = bus_valid && port_s == PORT_REG;
  assign ram_acc = bus_valid && port_s == PORT_RAM;
  assign rd_req  = bus_valid && !bus_write;

  cursor_ptr_unit u_ptr (
    .clk    (clk),
    .rst    (rst),
    .req_i  (bus_valid),
    .wr_i   (bus_write),
    .port_i (port_s),
    .byte_i (bus_wdata[BYTE_W-1:0]),
    .ptr_o  (ptr_q)
  );

  cursor_regfile u_regs (
    .clk     (clk),
    .rst     (rst),
    .we_i    (reg_acc && bus_write),
    .re_i    (reg_acc && !bus_write),
    .ptr_i   (ptr_q),
    .wdata_i (bus_wdata[BYTE_W-1:0]),
    .rdata_o (reg_rdata),
    .regs_o  (regs_flat)
  );

  cursor_bitmap_ram u_ram (
    .clk       (clk),
    .a_en_i    (ram_acc),
    .a_we_i    (bus_write),
    .a_addr_i  (ptr_q[RAM_AW-1:0]),
    .a_wdata_i (bus_wdata),
    .a_rdata_o (ram_rdata),
    .b_addr_i  (ovl_addr),
    .b_rdata_o (ovl_rdata)
  );

  // read return stage
  port_e             sel_q;
  logic [BYTE_W-1:0] ptrb_q;
  logic              rvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      sel_q    <= PORT_PTR_LO;
      ptrb_q   <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) begin
        sel_q  <= port_s;
        ptrb_q <= (port_s == PORT_PTR_HI) ? ptr_q[PTR_W-1:BYTE_W]
                                          : ptr_q[BYTE_W-1:0];
      end
    end
  end

  always_comb begin
    unique case (sel_q)
      PORT_RAM: bus_rdata = ram_rdata;
      PORT_REG: bus_rdata = {{(WORD_W-BYTE_W){1'b0}}, reg_rdata};
      default:  bus_rdata = {{(WORD_W-BYTE_W){1'b0}}, ptrb_q};
    endcase
  end
  assign bus_rvalid = rvalid_q;

  // field assembly for the overlay logic
  function automatic logic [BYTE_W-1:0] rb(input int idx);
    return regs_flat[idx*BYTE_W +: BYTE_W];
  endfunction

  assign cmd_o   = rb(IDX_CMD);
  assign cur_x_o = {rb(IDX_CX_HI)[COORD_HI_W-1:0], rb(IDX_CX_LO)};
  assign cur_y_o = {rb(IDX_CY_HI)[COORD_HI_W-1:0], rb(IDX_CY_LO)};
  assign win_x_o = {rb(IDX_WX_LO+1), rb(IDX_WX_LO)};
  assign win_y_o = {rb(IDX_WY_LO+1), rb(IDX_WY_LO)};
  assign win_w_o = {rb(IDX_WW_LO+1), rb(IDX_WW_LO)};
  assign win_h_o = {rb(IDX_WH_LO+1), rb(IDX_WH_LO)};

  logic [BYTE_W-COORD_HI_W-1:0] unused_hi;
  assign unused_hi = rb(IDX_CX_HI)[BYTE_W-1:COORD_HI_W] ^ rb(IDX_CY_HI)[BYTE_W-1:COORD_HI_W];
endmodule

// File: rtl/cursor_host_port_chk.sv
module cursor_host_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [1:0]  bus_port,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        bus_rvalid,
  input logic [15:0] ptr,
  input logic [7:0]  cmd_o,
  input logic [11:0] cur_x_o,
  input logic [11:0] cur_y_o,
  input logic [15:0] win_x_o,
  input logic [15:0] win_h_o
);
  p_rvalid_after_read_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid);
  p_no_rvalid_r1: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
  p_ptr_lo_load_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_port == 2'd0) |=>
      (ptr[7:0] == $past(bus_wdata[7:0]) && ptr[15:8] == $past(ptr[15:8])));
  p_reg_ptr_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_port == 2'd3) |=> ptr == $past(ptr) + 16'd1);
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_port == 2'd3) |=> bus_rdata[15:8] == 8'h00);
  p_hi_nibble_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_port == 2'd3 && (ptr == 16'd2 || ptr == 16'd4))
      |=> bus_rdata[7:4] == 4'h0);
  p_oob_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_port == 2'd3 && ptr > 16'd12) |=>
      ($stable(cmd_o) && $stable(cur_x_o) && $stable(cur_y_o) &&
       $stable(win_x_o) && $stable(win_h_o)));
  p_ram_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_port == 2'd2) |=>
      (ptr[15:9] == 7'd0 && ptr[8:0] == $past(ptr[8:0]) + 9'd1));
endmodule

bind cursor_host_port cursor_host_port_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_port   (bus_port),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .ptr        (ptr_q),
  .cmd_o      (cmd_o),
  .cur_x_o    (cur_x_o),
  .cur_y_o    (cur_y_o),
  .win_x_o    (win_x_o),
  .win_h_o    (win_h_o)
);

// File: tb/cursor_host_port_tb.sv
module cursor_host_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_port = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [8:0]  ovl_addr = 9'h0;
  logic [15:0] ovl_rdata;
  logic [7:0]  cmd_o;
  logic [11:0] cur_x_o, cur_y_o;
  logic [15:0] win_x_o, win_y_o, win_w_o, win_h_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cursor_host_port dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ovl_addr(ovl_addr), .ovl_rdata(ovl_rdata),
    .cmd_o(cmd_o), .cur_x_o(cur_x_o), .cur_y_o(cur_y_o), .win_x_o(win_x_o),
    .win_y_o(win_y_o), .win_w_o(win_w_o), .win_h_o(win_h_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request; returns data and rvalid seen one cycle later
  task automatic acc(input logic [1:0] p, input logic wr, input logic [15:0] wd,
                     output logic [15:0] rd, output logic rv);
    bus_valid = 1'b1; bus_write = wr; bus_port = p; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd = bus_rdata; rv = bus_rvalid;
  endtask

  task automatic wr(input logic [1:0] p, input logic [15:0] wd);
    logic [15:0] d; logic v;
    acc(p, 1'b1, wd, d, v);
  endtask

  task automatic rdw(input logic [1:0] p, output logic [15:0] d);
    logic v;
    acc(p, 1'b0, 16'h0, d, v);
  endtask

  task automatic set_ptr(input logic [15:0] a);
    wr(2'd0, {2{a[7:0]}});
    wr(2'd1, {2{a[15:8]}});
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'hA7 ^ 8'(i * 8'h3B);
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    rdw(2'd0, d); check("R11 ptr lo after reset", d, 16'h0);
    rdw(2'd1, d); check("R11 ptr hi after reset", d, 16'h0);
    for (int i = 0; i < 13; i++) begin
      rdw(2'd3, d); check($sformatf("R11 reg %0d after reset", i), d, 16'h0);
    end
    check("R11 outputs after reset",
          {cmd_o, cur_x_o, cur_y_o} | {16'h0, win_x_o | win_y_o | win_w_o | win_h_o}, 32'h0);
  endtask

  task automatic t_latency();
    logic [15:0] d; logic v;
    @(negedge clk); check("R1 rvalid idle", bus_rvalid, 1'b0);
    acc(2'd0, 1'b1, 16'h0000, d, v); check("R1 rvalid after write", v, 1'b0);
    acc(2'd1, 1'b0, 16'h0, d, v);    check("R1 rvalid after read", v, 1'b1);
    @(negedge clk); check("R1 rvalid drops", bus_rvalid, 1'b0);
  endtask

  task automatic t_ptr_load();
    logic [15:0] d;
    wr(2'd0, 16'h3434); wr(2'd1, 16'h0101);
    rdw(2'd0, d); check("R2 ptr lo readback", d, 16'h0034);
    rdw(2'd1, d); check("R2 ptr hi readback", d, 16'h0001);
    wr(2'd0, 16'h9999);
    rdw(2'd1, d); check("R2 hi kept on lo write", d, 16'h0001);
    rdw(2'd0, d); check("R2 lo updated", d, 16'h0099);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    logic [7:0] e;
    set_ptr(16'h0000);
    for (int i = 0; i < 13; i++) wr(2'd3, {2{pat(i)}});
    rdw(2'd0, d); check("R3 ptr after 13 reg writes", d, 16'h000D);
    check("R5 cmd", cmd_o, pat(0));
    check("R5 R6 cur_x", cur_x_o, {pat(2)[3:0], pat(1)});
    check("R5 R6 cur_y", cur_y_o, {pat(4)[3:0], pat(3)});
    check("R5 win_x", win_x_o, {pat(6), pat(5)});
    check("R5 win_y", win_y_o, {pat(8), pat(7)});
    check("R5 win_w", win_w_o, {pat(10), pat(9)});
    check("R5 win_h", win_h_o, {pat(12), pat(11)});
    set_ptr(16'h0000);
    for (int i = 0; i < 13; i++) begin
      e = (i == 2 || i == 4) ? (pat(i) & 8'h0F) : pat(i);
      rdw(2'd3, d); check($sformatf("R4 R6 reg %0d readback", i), d, {8'h00, e});
    end
  endtask

  task automatic t_oob();
    logic [15:0] d;
    set_ptr(16'h000D);
    wr(2'd3, 16'hFFFF);
    rdw(2'd0, d); check("R7 ptr advances past 13", d, 16'h000E);
    check("R7 cmd untouched", cmd_o, pat(0));
    check("R7 win_h untouched", win_h_o, {pat(12), pat(11)});
    set_ptr(16'h0100);
    wr(2'd3, 16'h5A5A);
    rdw(2'd0, d); check("R7 ptr lo 0x100+1", d, 16'h0001);
    set_ptr(16'h000D);
    rdw(2'd3, d); check("R7 read above 12 is zero", d, 16'h0000);
    set_ptr(16'h0000);
    rdw(2'd3, d); check("R7 reg 0 kept after 0x100 write", d, {8'h00, pat(0)});
  endtask

  task automatic t_ram();
    logic [15:0] d;
    set_ptr(16'h01FE);
    wr(2'd2, 16'hA5C3); wr(2'd2, 16'h1234);
    rdw(2'd0, d); check("R9 ptr lo wraps", d, 16'h0000);
    rdw(2'd1, d); check("R9 ptr hi wraps", d, 16'h0000);
    wr(2'd2, 16'hBEEF);
    set_ptr(16'h01FE);
    rdw(2'd2, d); check("R8 word 1FE", d, 16'hA5C3);
    rdw(2'd2, d); check("R8 word 1FF", d, 16'h1234);
    rdw(2'd2, d); check("R8 R9 word 000", d, 16'hBEEF);
    set_ptr(16'h7A10);
    wr(2'd2, 16'h0F0F);
    rdw(2'd1, d); check("R9 high bits cleared", d, 16'h0000);
    rdw(2'd0, d); check("R9 low index +1", d, 16'h0011);
    set_ptr(16'h0010);
    rdw(2'd2, d); check("R8 index from ptr[8:0]", d, 16'h0F0F);
  endtask

  task automatic t_ovl();
    ovl_addr = 9'h1FF; @(negedge clk);
    check("R10 overlay 1FF", ovl_rdata, 16'h1234);
    ovl_addr = 9'h010; @(negedge clk);
    check("R10 overlay 010", ovl_rdata, 16'h0F0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latency();
    t_ptr_load();
    t_regs();
    t_oob();
    t_ram();
    t_ovl();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule